// File: doc/BRIEF.md
# Source-Routed Wormhole Crossbar Switch

This block is one switching element of a multi-stage network. It has four inputs and four outputs. Packets cross it one flit at a time under valid/ready handshakes. The sender writes the whole path into the first flit of a packet: a 2-bit output selector for each switch the packet will cross, with the selector for the nearest switch in the lowest bits. The switch holds no tables. It reads the lowest selector, shifts the head right by two bits so that the next switch finds its own selector at the bottom, and forwards the head in the same cycle it arrives.

A head flit requests one output. Every output runs its own round-robin arbiter over the heads that want it. Once the granted head is accepted, the output stays connected to that input until the tail flit passes, so packets never interleave on an output. A head that loses stays on its input with ready held low. Everything behind it waits in place, which is wormhole switching, and the switch keeps no flit storage of its own.

Flits are 16 data bits plus a head marker and a tail marker. A packet of one flit sets both markers.

Top module: `srcroute_xbar`

## Requirements
- R1: While reset is held and on the first cycle after it, with no input valid, every out_valid and every in_ready is 0.
- R2: A head flit is routed to the output whose index equals bits [1:0] of its data. The other outputs stay idle.
- R3: A head flit leaves the switch with its data shifted right by 2 and its top 2 bits zero. Body and tail flits pass through unchanged.
- R4: An uncontested head appears on its output in the same cycle it is presented, with no register on the data path.
- R5: After an output accepts a head, it carries only flits from that input until the tail. A competing head for that output sees in_ready low for the whole time.
- R6: An output is free again on the cycle after its tail flit is accepted. A waiting head can then pass at once, with no idle cycle between packets.
- R7: A flit with both head and tail set claims and releases its output in one transfer. Single-flit packets from different inputs can therefore leave one output on consecutive cycles.
- R8: Each output grants among its competing heads in round-robin order. After reset, input 0 has the highest priority. After each accepted head, priority starts at the input just above the one granted, wrapping from 3 to 0.
- R9: When out_ready is low, in_ready of the connected input is low and the output holds the same flit. Flit order and content do not change across a stall.
- R10: Packets going to different outputs move at the same time without affecting each other. An input is connected to at most one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 4 | Flit valid, one bit per input |
| in_ready | output | 4 | Flit accepted this cycle, one bit per input |
| in_data | input | 64 | Flit data, input i at bits [16i+15:16i] |
| in_head | input | 4 | First-flit marker per input |
| in_tail | input | 4 | Last-flit marker per input |
| out_valid | output | 4 | Flit valid, one bit per output |
| out_ready | input | 4 | Downstream can take a flit, one bit per output |
| out_data | output | 64 | Flit data, output o at bits [16o+15:16o], head already shifted |
| out_head | output | 4 | First-flit marker per output |
| out_tail | output | 4 | Last-flit marker per output |

## Verification
The hardest state to reach is an output whose arbiter pointer sits in the middle of its range while two inputs are still competing. The stimulus gets there with two inputs that each send back-to-back single-flit packets to the same output. The pointer then moves on every cycle, and only a real round-robin gives the alternating order 0, 2, 0, 2. Head blocking and a mid-packet stall are produced with two multi-flit packets that start in the same cycle and with out_ready dropped in the middle of a body. The contention cases also check that the winning packet and the waiting packet leave on consecutive cycles.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    LNK_IDLE = 1'b0,
    LNK_HELD = 1'b1
  } link_st_e;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] ptr;

  // index following a granted slot, with wrap
  function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] s);
    return (int'(s) == N - 1) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        gidx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             ptr <= '0;
    else if (adv && any) ptr <= next_slot(gidx);
  end

  // R8: at most one winner, and only among requesters
  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
  import xbar_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int SW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    in_valid,
  input  logic [N*DW-1:0] in_data,
  input  logic [N-1:0]    in_head,
  input  logic [N-1:0]    in_tail,
  input  logic            out_ready,
  output logic [N-1:0]    sel,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            out_head,
  output logic            out_tail
);
  link_st_e      st;
  logic [IW-1:0] owner;
  logic [N-1:0]  gnt;
  logic [IW-1:0] gidx;
  logic          g_any;
  logic          held;
  logic          xfer;
  logic          head_taken;
  logic          tail_taken;
  logic [DW-1:0] raw_data;

  // shift the consumed selector out of a head flit
  function automatic logic [DW-1:0] strip_sel(input logic [DW-1:0] d);
    return d >> SW;
  endfunction

  assign held = (st == LNK_HELD);

  xbar_rr_arb #(.N(N)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (held ? '0 : req),
    .adv  (head_taken),
    .gnt  (gnt),
    .gidx (gidx),
    .any  (g_any)
  );

  always_comb begin
    sel = held ? (N'(1) << owner) : gnt;
    out_valid = 1'b0;
    raw_data  = '0;
    out_head  = 1'b0;
    out_tail  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        out_valid = in_valid[i];
        raw_data  = in_data[i*DW +: DW];
        out_head  = in_head[i];
        out_tail  = in_tail[i];
      end
    end
    out_data = out_head ? strip_sel(raw_data) : raw_data;
  end

  assign xfer       = out_valid && out_ready;
  assign head_taken = xfer && !held && g_any;
  assign tail_taken = xfer && out_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LNK_IDLE;
      owner <= '0;
    end else if (head_taken && !out_tail) begin
      st    <= LNK_HELD;
      owner <= gidx;
    end else if (held && tail_taken) begin
      st    <= LNK_IDLE;
    end
  end

  // R5: a held link keeps its owner until the tail passes
  a_r5_link_hold: assert property (@(posedge clk) disable iff (rst)
    (held && !tail_taken) |=> (held && $stable(owner)));

  // R6: accepted tail frees the output for the next cycle
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    tail_taken |=> !held);

  // R7: a head that is also a tail never leaves the output held
  a_r7_single_flit: assert property (@(posedge clk) disable iff (rst)
    (!held && xfer && out_head && out_tail) |=> !held);

  // R3: forwarded heads carry zeros in the vacated top bits
  a_r3_head_stripped: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_head) |-> (out_data[DW-1 -: SW] == '0));

  // R5: at most one input drives this output
  a_r5_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/srcroute_xbar.sv
module srcroute_xbar #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 16,
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*DATA_W-1:0] in_data,
  input  logic [NPORT-1:0]        in_head,
  input  logic [NPORT-1:0]        in_tail,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*DATA_W-1:0] out_data,
  output logic [NPORT-1:0]        out_head,
  output logic [NPORT-1:0]        out_tail
);
  logic [NPORT-1:0] req_to [NPORT];
  logic [NPORT-1:0] sel_m  [NPORT];
  logic [NPORT-1:0] link_of [NPORT];

  // the selector this switch consumes sits in the lowest bits
  function automatic logic [SEL_W-1:0] port_of(input logic [DATA_W-1:0] d);
    return d[SEL_W-1:0];
  endfunction

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_to[o][i] = in_valid[i] && in_head[i] &&
                       (port_of(in_data[i*DATA_W +: DATA_W]) == SEL_W'(o));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_out_port #(.N(NPORT), .DW(DATA_W), .SW(SEL_W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req       (req_to[o]),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_head   (in_head),
      .in_tail   (in_tail),
      .out_ready (out_ready[o]),
      .sel       (sel_m[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*DATA_W +: DATA_W]),
      .out_head  (out_head[o]),
      .out_tail  (out_tail[o])
    );
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_ready[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        link_of[i][o] = sel_m[o][i];
        in_ready[i]   = in_ready[i] | (sel_m[o][i] & out_ready[o]);
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R10: an input is linked to no more than one output
    a_r10_single_link: assert property (@(posedge clk) disable iff (rst)
      $countones(link_of[i]) <= 1);
    // R9: an input is never told ready without some output taking it
    a_r9_ready_has_taker: assert property (@(posedge clk) disable iff (rst)
      in_ready[i] |-> ((link_of[i] & out_ready) != '0));
  end
endmodule

// File: tb/sim_srcroute_xbar.sv
module sim_srcroute_xbar;
  localparam int N  = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst  = 1'b1;
  logic [N-1:0]    iv   = '0;
  logic [N-1:0]    ih   = '0;
  logic [N-1:0]    it   = '0;
  logic [N*DW-1:0] idat = '0;
  logic [N-1:0]    ordy = '1;
  logic [N-1:0]    ird, ov, oh, ot;
  logic [N*DW-1:0] odat;

  srcroute_xbar #(.NPORT(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(iv), .in_ready(ird), .in_data(idat), .in_head(ih), .in_tail(it),
    .out_valid(ov), .out_ready(ordy), .out_data(odat), .out_head(oh), .out_tail(ot)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [17:0] mon_q [N][$];
  int          mcy_q [N][$];
  logic [17:0] exp_q [N][$];

  // record every accepted output flit just before the clock edge
  always begin
    @(negedge clk);
    #4;
    for (int o = 0; o < N; o++) begin
      if (!rst && ov[o] && ordy[o]) begin
        mon_q[o].push_back({oh[o], ot[o], odat[o*DW +: DW]});
        mcy_q[o].push_back(cyc);
      end
    end
  end

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
    end
  endtask

  function automatic logic [15:0] head_word(input logic [7:0] tag, input int port);
    return {tag, 6'(tag ^ 8'h2d), 2'(port)};
  endfunction

  function automatic logic [17:0] out_flit(input logic [7:0] tag, input int k,
                                           input int len, input int port);
    logic [15:0] d;
    d = (k == 0) ? (head_word(tag, port) >> 2) : {tag, 8'(k)};
    return {k == 0, k == len - 1, d};
  endfunction

  task automatic exp_pkt(input int o, input logic [7:0] tag, input int len);
    for (int k = 0; k < len; k++) exp_q[o].push_back(out_flit(tag, k, len, o));
  endtask

  task automatic drive_pkt(input int i, input int port, input int len,
                           input logic [7:0] tag);
    for (int k = 0; k < len; k++) begin
      bit acc;
      iv[i] = 1'b1;
      ih[i] = (k == 0);
      it[i] = (k == len - 1);
      idat[i*DW +: DW] = (k == 0) ? head_word(tag, port) : {tag, 8'(k)};
      do begin
        #4;
        acc = ird[i];
        @(negedge clk);
      end while (!acc);
    end
    iv[i] = 1'b0;
    ih[i] = 1'b0;
    it[i] = 1'b0;
  endtask

  task automatic chk_out(input int o, input string r, input bit contig);
    chk(r, $sformatf("flit count out%0d", o), mon_q[o].size(), exp_q[o].size());
    for (int k = 0; k < exp_q[o].size() && k < mon_q[o].size(); k++)
      chk(r, $sformatf("out%0d flit %0d", o, k), mon_q[o][k], exp_q[o][k]);
    if (contig)
      for (int k = 1; k < mcy_q[o].size(); k++)
        chk("R6", $sformatf("out%0d gap before flit %0d", o, k),
            mcy_q[o][k] - mcy_q[o][k-1], 1);
    mon_q[o].delete();
    mcy_q[o].delete();
    exp_q[o].delete();
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #4;
    chk("R1", "out_valid in reset", ov, 0);
    chk("R1", "in_ready in reset", ird, 0);
    @(negedge clk);
    rst = 1'b0;
    #4;
    chk("R1", "out_valid after reset", ov, 0);
    chk("R1", "in_ready after reset", ird, 0);
    @(negedge clk);
  endtask

  task automatic t_route_strip;
    fork
      drive_pkt(0, 2, 3, 8'h11);
      begin
        #4;
        chk("R4", "head visible same cycle", ov[2], 1);
        chk("R3", "stripped head data", odat[2*DW +: DW], head_word(8'h11, 2) >> 2);
        chk("R2", "other outputs idle", ov & 4'b1011, 0);
      end
    join
    exp_pkt(2, 8'h11, 3);
    for (int o = 0; o < N; o++) chk_out(o, "R2 R3", 1);
  endtask

  task automatic t_contend;
    fork
      drive_pkt(1, 0, 3, 8'h21);
      drive_pkt(3, 0, 3, 8'h23);
      begin
        #4;
        chk("R5", "winner ready", ird[1], 1);
        chk("R5", "loser blocked", ird[3], 0);
        @(negedge clk);
        #4;
        chk("R5", "loser blocked mid packet", ird[3], 0);
      end
    join
    exp_pkt(0, 8'h21, 3);
    exp_pkt(0, 8'h23, 3);
    chk_out(0, "R5", 1);
  endtask

  task automatic t_single_flit;
    fork
      drive_pkt(0, 1, 1, 8'h40);
      drive_pkt(1, 1, 1, 8'h41);
      drive_pkt(2, 1, 1, 8'h42);
      drive_pkt(3, 1, 1, 8'h43);
    join
    for (int i = 0; i < N; i++) exp_pkt(1, 8'(8'h40 + i), 1);
    chk_out(1, "R7", 1);
  endtask

  task automatic t_round_robin;
    fork
      begin drive_pkt(0, 3, 1, 8'h50); drive_pkt(0, 3, 1, 8'h51); end
      begin drive_pkt(2, 3, 1, 8'h52); drive_pkt(2, 3, 1, 8'h53); end
    join
    exp_pkt(3, 8'h50, 1);
    exp_pkt(3, 8'h52, 1);
    exp_pkt(3, 8'h51, 1);
    exp_pkt(3, 8'h53, 1);
    chk_out(3, "R8", 1);
  endtask

  task automatic t_stall;
    fork
      drive_pkt(0, 1, 4, 8'h60);
      begin
        logic [15:0] held_d;
        @(negedge clk);
        ordy[1] = 1'b0;
        #4;
        chk("R9", "input ready during stall", ird[0], 0);
        chk("R9", "output valid during stall", ov[1], 1);
        held_d = odat[DW +: DW];
        @(negedge clk);
        #4;
        chk("R9", "data held during stall", odat[DW +: DW], held_d);
        chk("R9", "input still stalled", ird[0], 0);
        @(negedge clk);
        ordy[1] = 1'b1;
      end
    join
    exp_pkt(1, 8'h60, 4);
    chk_out(1, "R9", 0);
  endtask

  task automatic t_parallel;
    int first [N];
    fork
      drive_pkt(0, 3, 2, 8'h70);
      drive_pkt(1, 2, 2, 8'h71);
      drive_pkt(2, 1, 2, 8'h72);
      drive_pkt(3, 0, 2, 8'h73);
    join
    for (int o = 0; o < N; o++) begin
      first[o] = (mcy_q[o].size() > 0) ? mcy_q[o][0] : -1;
      exp_pkt(o, 8'(8'h73 - o), 2);
    end
    for (int o = 1; o < N; o++)
      chk("R10", $sformatf("out%0d starts with out0", o), first[o], first[0]);
    for (int o = 0; o < N; o++) chk_out(o, "R10", 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_route_strip();
    t_contend();
    t_single_flit();
    t_round_robin();
    t_stall();
    t_parallel();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule